// File: doc/BRIEF.md
# Character Display Instruction Unit

This block is the command side of a dot-matrix character display controller. A host presents one complete register access per cycle: a register-select bit, a read/write bit and an 8-bit value. With the select bit low, a write is an instruction and a read returns the status word. With the select bit high, the access moves a byte to or from the display-data RAM (128 bytes) or the character-generator RAM (64 bytes), both held inside the block. The unit keeps the mode flags, a 7-bit address counter, the horizontal display offset and an execution timer that holds the busy flag high while an instruction runs.

The scanning logic reads the mode flags and the display offset. The host polls the busy flag through the status read. Instructions that arrive while busy are refused and flagged. Data reads go through a one-byte prefetch latch. The latch is refilled after an address set, after a cursor move and after each data read. A data read that follows any other operation therefore returns an old byte.

Top module: `chardisp_cmd_unit`

## Requirements
- R1: With select=0 and write, the highest set bit of the value selects the instruction: bit7 sets the display address (bits 6:0), bit6 sets the glyph address (bits 5:0), bit5 is function set, bit4 is shift, bit3 is display control, bit2 is entry mode, bit1 is home, bit0 is clear. Bits below the operand field are ignored. A value of 0x00 is a no-op.
- R2: Clear (0x01) sets all 128 display bytes to 0x20, sets the address counter and the display offset to 0, selects display RAM and forces the increment direction.
- R3: Home (0x02/0x03) sets the address counter and the offset to 0 and selects display RAM. RAM contents are unchanged.
- R4: Clear and home keep the unit busy for ceil(1530 us × OSC_KHZ / 1000) cycles (414 at 270 kHz). Data accesses keep it busy for ceil(43 us ×) cycles (12). Every other instruction, including the no-op, keeps it busy for ceil(39 us ×) cycles (11). A status read (select=0, read) costs no time, is accepted while busy and returns {busy, address counter} in bits 7 and 6:0 on the next cycle.
- R5: Any access other than a status read that arrives while busy is discarded. proto_err goes high for the following cycle, and no state changes.
- R6: After each data write or read, the address counter steps by one: up when entry bit1 (increment) is 1, down when it is 0. In glyph RAM the counter wraps modulo 64.
- R7: In two-line mode (function bit3=1), stepping up goes 0x27→0x40 and 0x67→0x00, and stepping down does the reverse. In one-line mode, stepping wraps between 0x4F and 0x00.
- R8: When entry bit0 is 1, a display-RAM write also moves the offset: left (+1) when incrementing, right (−1) when decrementing. The offset wraps modulo 40 in two-line mode and modulo 80 in one-line mode. Reads and glyph writes never move it.
- R9: In the shift instruction, bit3=0 moves the cursor (bit2=1 up, 0 down, with the R7 wrap rules). bit3=1 moves the display (bit2=1 right, −1; 0 left, +1) and leaves the address counter unchanged.
- R10: A data read returns the prefetch latch. The latch is loaded from the addressed RAM after an address set, a cursor move or a data read. A read after a data write returns the byte prefetched before the write.
- R11: Display control bits 2/1/0 drive disp_on, cursor_on and blink_on. Function set bits 4/3/2 drive bus_8bit, two_line and tall_font. After reset: display, cursor and blink off, one-line mode, 8-bit bus, short font, increment without shift.
- R12: rd_data changes only on the cycle after an accepted read and holds its value otherwise. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the internal oscillator rate |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One access presented this cycle |
| acc_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| acc_rw | input | 1 | 1 read, 0 write |
| acc_data | input | 8 | Instruction or write value |
| rd_data | output | 8 | Result of the last accepted read |
| busy | output | 1 | Execution in progress |
| proto_err | output | 1 | Access refused while busy (one cycle) |
| disp_on | output | 1 | Display enabled |
| cursor_on | output | 1 | Cursor shown |
| blink_on | output | 1 | Cursor blinking |
| two_line | output | 1 | Two-line addressing mode |
| tall_font | output | 1 | Tall glyph format |
| bus_8bit | output | 1 | 8-bit host bus selected |
| shift_ofs | output | 7 | Current display offset |

## Verification
On every cycle, the assertions check the state after clear and after home, the status word returned by a status read, that a refused access leaves the counter and the offset untouched, and that busy rises only when an instruction is accepted. The order-dependent behaviour shows only in the bench's scenarios, where a behavioural model is compared on every clock. This covers the stale byte returned after a write, the line-to-line address wraps in both directions and both line modes, the offset moving with writes but not with reads, and the exact busy length of each instruction class.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

    localparam int AC_W      = 7;
    localparam int CG_W      = 6;
    localparam int LINE_LEN  = 40;
    localparam logic [AC_W-1:0] L1_LAST  = 7'h27;
    localparam logic [AC_W-1:0] L2_FIRST = 7'h40;
    localparam logic [AC_W-1:0] L2_LAST  = 7'h67;
    localparam logic [AC_W-1:0] ONE_LAST = 7'h4F;

    typedef enum logic [3:0] {
        OP_NOP, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP, OP_SHIFT,
        OP_FUNC, OP_CGADR, OP_DDADR, OP_STATUS, OP_WRITE, OP_READ
    } op_e;

    typedef struct packed {
        logic inc;
        logic shd;
        logic disp;
        logic cur;
        logic blink;
        logic bus8;
        logic two;
        logic tall;
    } mode_t;

    localparam mode_t MODE_RESET = '{inc: 1'b1, shd: 1'b0, disp: 1'b0, cur: 1'b0,
                                     blink: 1'b0, bus8: 1'b1, two: 1'b0, tall: 1'b0};

    function automatic logic [AC_W-1:0] ac_step(input logic [AC_W-1:0] ac,
                                                input logic up, input logic two,
                                                input logic cg);
        if (cg) begin
            if (up) return {1'b0, ac[CG_W-1:0] + 6'd1};
            return {1'b0, ac[CG_W-1:0] - 6'd1};
        end
        if (up) begin
            if (two && ac == L1_LAST)  return L2_FIRST;
            if (two && ac == L2_LAST)  return '0;
            if (!two && ac == ONE_LAST) return '0;
            return ac + 7'd1;
        end
        if (two && ac == '0)       return L2_LAST;
        if (two && ac == L2_FIRST) return L1_LAST;
        if (!two && ac == '0)      return ONE_LAST;
        return ac - 7'd1;
    endfunction

    function automatic logic [AC_W-1:0] ofs_step(input logic [AC_W-1:0] ofs,
                                                 input logic left, input logic two);
        logic [AC_W-1:0] top;
        top = two ? 7'(LINE_LEN - 1) : 7'(2 * LINE_LEN - 1);
        if (left) return (ofs >= top) ? '0 : ofs + 7'd1;
        return (ofs == '0) ? top : ofs - 7'd1;
    endfunction

endpackage

// File: rtl/chardisp_decode.sv
module chardisp_decode
    import chardisp_pkg::*;
(
    input  logic       rs,
    input  logic       rw,
    input  logic [7:0] val,
    output op_e        op
);
    always_comb begin
        op = OP_NOP;
        if (rs)          op = rw ? OP_READ : OP_WRITE;
        else if (rw)     op = OP_STATUS;
        else if (val[7]) op = OP_DDADR;
        else if (val[6]) op = OP_CGADR;
        else if (val[5]) op = OP_FUNC;
        else if (val[4]) op = OP_SHIFT;
        else if (val[3]) op = OP_DISP;
        else if (val[2]) op = OP_ENTRY;
        else if (val[1]) op = OP_HOME;
        else if (val[0]) op = OP_CLEAR;
    end
endmodule

// File: rtl/chardisp_timer.sv
module chardisp_timer #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] load,
    output logic          busy
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (start)       cnt <= load;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    p_busy_rise_needs_start_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
    p_start_makes_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (start && load != '0) |=> busy);
endmodule

// File: rtl/chardisp_store.sv
module chardisp_store #(
    parameter int DD_DEPTH = 128,
    parameter int CG_DEPTH = 64,
    parameter logic [7:0] BLANK = 8'h20
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        we,
    input  logic                        cg_sel,
    input  logic [$clog2(DD_DEPTH)-1:0] addr,
    input  logic [7:0]                  wdata,
    output logic [7:0]                  rdata
);
    localparam int CGA = $clog2(CG_DEPTH);

    logic [7:0] dd [DD_DEPTH];
    logic [7:0] cg [CG_DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < DD_DEPTH; i++) dd[i] <= BLANK;
        end else if (we && !cg_sel) begin
            dd[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CG_DEPTH; i++) cg[i] <= '0;
        end else if (we && cg_sel) begin
            cg[addr[CGA-1:0]] <= wdata;
        end
    end

    assign rdata = cg_sel ? cg[addr[CGA-1:0]] : dd[addr];
endmodule

// File: rtl/chardisp_cmd_unit.sv
module chardisp_cmd_unit
    import chardisp_pkg::*;
#(
    parameter int OSC_KHZ = 270
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_valid,
    input  logic       acc_rs,
    input  logic       acc_rw,
    input  logic [7:0] acc_data,
    output logic [7:0] rd_data,
    output logic       busy,
    output logic       proto_err,
    output logic       disp_on,
    output logic       cursor_on,
    output logic       blink_on,
    output logic       two_line,
    output logic       tall_font,
    output logic       bus_8bit,
    output logic [6:0] shift_ofs
);
    localparam int LONG_CYC = (1530 * OSC_KHZ + 999) / 1000;
    localparam int STD_CYC  = (39 * OSC_KHZ + 999) / 1000;
    localparam int DATA_CYC = (43 * OSC_KHZ + 999) / 1000;
    localparam int CW       = $clog2(LONG_CYC + 1);

    op_e             op;
    mode_t           mode_q;
    logic [AC_W-1:0] ac_q, ofs_q;
    logic            cg_q, refill_q;
    logic [7:0]      latch_q, ram_rd;
    logic [CW-1:0]   cost;
    logic            is_status, accept, status_rd;

    chardisp_decode u_dec (.rs(acc_rs), .rw(acc_rw), .val(acc_data), .op(op));

    assign is_status = (op == OP_STATUS);
    assign accept    = acc_valid && !busy && !is_status;
    assign status_rd = acc_valid && is_status;

    always_comb begin
        unique case (op)
            OP_CLEAR, OP_HOME: cost = CW'(LONG_CYC);
            OP_WRITE, OP_READ: cost = CW'(DATA_CYC);
            default:           cost = CW'(STD_CYC);
        endcase
    end

    chardisp_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst(rst), .start(accept), .load(cost), .busy(busy)
    );

    chardisp_store u_ram (
        .clk(clk), .rst(rst), .clr(accept && op == OP_CLEAR),
        .we(accept && op == OP_WRITE), .cg_sel(cg_q), .addr(ac_q),
        .wdata(acc_data), .rdata(ram_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_RESET;
            ac_q      <= '0;
            ofs_q     <= '0;
            cg_q      <= 1'b0;
            refill_q  <= 1'b0;
            latch_q   <= '0;
            rd_data   <= '0;
            proto_err <= 1'b0;
        end else begin
            proto_err <= acc_valid && busy && !is_status;
            refill_q  <= 1'b0;
            if (refill_q)  latch_q <= ram_rd;
            if (status_rd) rd_data <= {busy, ac_q};
            if (accept) begin
                unique case (op)
                    OP_CLEAR: begin
                        ac_q <= '0; ofs_q <= '0; cg_q <= 1'b0; mode_q.inc <= 1'b1;
                    end
                    OP_HOME: begin
                        ac_q <= '0; ofs_q <= '0; cg_q <= 1'b0;
                    end
                    OP_ENTRY: begin
                        mode_q.inc <= acc_data[1]; mode_q.shd <= acc_data[0];
                    end
                    OP_DISP: begin
                        mode_q.disp  <= acc_data[2];
                        mode_q.cur   <= acc_data[1];
                        mode_q.blink <= acc_data[0];
                    end
                    OP_SHIFT: begin
                        if (!acc_data[3]) begin
                            ac_q     <= ac_step(ac_q, acc_data[2], mode_q.two, cg_q);
                            refill_q <= 1'b1;
                        end else begin
                            ofs_q <= ofs_step(ofs_q, !acc_data[2], mode_q.two);
                        end
                    end
                    OP_FUNC: begin
                        mode_q.bus8 <= acc_data[4];
                        mode_q.two  <= acc_data[3];
                        mode_q.tall <= acc_data[2];
                    end
                    OP_CGADR: begin
                        ac_q <= {1'b0, acc_data[5:0]}; cg_q <= 1'b1; refill_q <= 1'b1;
                    end
                    OP_DDADR: begin
                        ac_q <= acc_data[6:0]; cg_q <= 1'b0; refill_q <= 1'b1;
                    end
                    OP_WRITE: begin
                        ac_q <= ac_step(ac_q, mode_q.inc, mode_q.two, cg_q);
                        if (!cg_q && mode_q.shd)
                            ofs_q <= ofs_step(ofs_q, mode_q.inc, mode_q.two);
                    end
                    OP_READ: begin
                        rd_data  <= latch_q;
                        ac_q     <= ac_step(ac_q, mode_q.inc, mode_q.two, cg_q);
                        refill_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign disp_on   = mode_q.disp;
    assign cursor_on = mode_q.cur;
    assign blink_on  = mode_q.blink;
    assign two_line  = mode_q.two;
    assign tall_font = mode_q.tall;
    assign bus_8bit  = mode_q.bus8;
    assign shift_ofs = ofs_q;

    p_clear_state_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_CLEAR) |=> (ac_q == '0 && ofs_q == '0 && mode_q.inc && !cg_q));
    p_home_state_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_HOME) |=> (ac_q == '0 && ofs_q == '0));
    p_status_word_r4: assert property (@(posedge clk) disable iff (rst)
        status_rd |=> (rd_data == {$past(busy), $past(ac_q)}));
    p_refused_no_change_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && busy && !is_status) |=> ($stable(ac_q) && $stable(ofs_q) && $stable(mode_q)));
    p_err_needs_busy_r5: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> $past(busy));
    p_rd_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !$past(status_rd) && !$past(accept && op == OP_READ) |-> $stable(rd_data));
endmodule

// File: tb/chardisp_cmd_unit_test.sv
module chardisp_cmd_unit_test;
    logic clk = 1'b0, rst = 1'b1;
    logic v = 1'b0, rs = 1'b0, rw = 1'b0;
    logic [7:0] d = 8'h00;
    logic [7:0] rd_data;
    logic [6:0] shift_ofs;
    logic busy, proto_err, disp_on, cursor_on, blink_on, two_line, tall_font, bus_8bit;

    chardisp_cmd_unit uut (
        .clk(clk), .rst(rst), .acc_valid(v), .acc_rs(rs), .acc_rw(rw), .acc_data(d),
        .rd_data(rd_data), .busy(busy), .proto_err(proto_err), .disp_on(disp_on),
        .cursor_on(cursor_on), .blink_on(blink_on), .two_line(two_line),
        .tall_font(tall_font), .bus_8bit(bus_8bit), .shift_ofs(shift_ofs)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    string cur_req = "R11";
    bit armed = 0;

    // behavioural reference state
    int m_ac, m_ofs, m_rd, m_latch, m_left;
    bit m_inc, m_sh, m_disp, m_cur, m_blink, m_bus8, m_two, m_tall, m_cg, m_err, bz;
    int cost;
    logic [7:0] m_dd [128];
    logic [7:0] m_cgr [64];

    function automatic int m_step(int a, bit up);
        if (m_cg) return up ? (a + 1) % 64 : (a + 63) % 64;
        if (m_two) begin
            if (up) return (a == 39) ? 64 : (a == 103) ? 0 : a + 1;
            return (a == 0) ? 103 : (a == 64) ? 39 : a - 1;
        end
        if (up) return (a == 79) ? 0 : a + 1;
        return (a == 0) ? 79 : a - 1;
    endfunction

    function automatic int m_move(int o, bit left);
        int len = m_two ? 40 : 80;
        return left ? (o + 1) % len : (o + len - 1) % len;
    endfunction

    function automatic int m_fetch();
        return m_cg ? int'(m_cgr[m_ac % 64]) : int'(m_dd[m_ac]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ac = 0; m_ofs = 0; m_rd = 0; m_latch = 0; m_left = 0; m_err = 0;
            m_inc = 1; m_sh = 0; m_disp = 0; m_cur = 0; m_blink = 0;
            m_bus8 = 1; m_two = 0; m_tall = 0; m_cg = 0;
            foreach (m_dd[i]) m_dd[i] = 8'h20;
            foreach (m_cgr[i]) m_cgr[i] = 8'h00;
        end else begin
            bz = (m_left > 0);
            m_err = 0;
            cost = 0;
            if (v && !rs && rw) m_rd = (bz ? 128 : 0) + m_ac;
            else if (v && bz) m_err = 1;
            else if (v) begin
                cost = 11;
                if (rs) begin
                    cost = 12;
                    if (rw) begin
                        m_rd = m_latch;
                        m_ac = m_step(m_ac, m_inc);
                        m_latch = m_fetch();
                    end else begin
                        if (m_cg) m_cgr[m_ac % 64] = d;
                        else begin
                            m_dd[m_ac] = d;
                            if (m_sh) m_ofs = m_move(m_ofs, m_inc);
                        end
                        m_ac = m_step(m_ac, m_inc);
                    end
                end
                else if (d[7]) begin m_ac = int'(d[6:0]); m_cg = 0; m_latch = m_fetch(); end
                else if (d[6]) begin m_ac = int'(d[5:0]); m_cg = 1; m_latch = m_fetch(); end
                else if (d[5]) begin m_bus8 = d[4]; m_two = d[3]; m_tall = d[2]; end
                else if (d[4]) begin
                    if (!d[3]) begin m_ac = m_step(m_ac, d[2]); m_latch = m_fetch(); end
                    else m_ofs = m_move(m_ofs, !d[2]);
                end
                else if (d[3]) begin m_disp = d[2]; m_cur = d[1]; m_blink = d[0]; end
                else if (d[2]) begin m_inc = d[1]; m_sh = d[0]; end
                else if (d[1]) begin m_ac = 0; m_ofs = 0; m_cg = 0; cost = 414; end
                else if (d[0]) begin
                    foreach (m_dd[i]) m_dd[i] = 8'h20;
                    m_ac = 0; m_ofs = 0; m_cg = 0; m_inc = 1; cost = 414;
                end
            end
            if (cost > 0) m_left = cost;
            else if (m_left > 0) m_left--;
        end
    end

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed) begin
            chk("busy", int'(busy), int'(m_left > 0));
            chk("rd_data", int'(rd_data), m_rd);
            chk("proto_err", int'(proto_err), int'(m_err));
            chk("shift_ofs", int'(shift_ofs), m_ofs);
            chk("flags", int'({disp_on, cursor_on, blink_on, two_line, tall_font, bus_8bit}),
                int'({m_disp, m_cur, m_blink, m_two, m_tall, m_bus8}));
        end
    end

    task automatic acc(bit s, bit r, logic [7:0] val);
        @(negedge clk);
        v = 1'b1; rs = s; rw = r; d = val;
        @(negedge clk);
        v = 1'b0;
    endtask

    task automatic idle();
        while (m_left > 0) @(negedge clk);
    endtask

    task automatic run(bit s, bit r, logic [7:0] val);
        acc(s, r, val);
        idle();
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL %s watchdog expired actual=hung expected=done", cur_req);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur_req = "R12";
        chk("reset rd_data", int'(rd_data), 0);
        cur_req = "R11";
        chk("reset busy", int'(busy), 0);
        chk("reset flags", int'({disp_on, cursor_on, blink_on, two_line, tall_font, bus_8bit}), 1);
        armed = 1;

        cur_req = "R4";  run(0, 1, 8'h00);
        cur_req = "R1";  run(0, 0, 8'h3F);
        cur_req = "R11"; run(0, 0, 8'h38); run(0, 0, 8'h0F); run(0, 0, 8'h0A);
        cur_req = "R12"; run(0, 0, 8'h00);
        cur_req = "R6";  run(0, 0, 8'h06);
        run(1, 0, 8'h41); run(1, 0, 8'h42); run(1, 0, 8'h43); run(0, 1, 8'h00);
        cur_req = "R10";
        run(0, 0, 8'h80); run(1, 1, 8'h00); run(1, 1, 8'h00);
        run(1, 0, 8'h58); run(1, 1, 8'h00); run(0, 1, 8'h00);
        cur_req = "R7";
        run(0, 0, 8'hA7); run(1, 0, 8'h31); run(0, 1, 8'h00);
        run(0, 0, 8'hE7); run(1, 0, 8'h32); run(0, 1, 8'h00);
        run(0, 0, 8'h04);
        run(0, 0, 8'hC0); run(1, 0, 8'h33); run(0, 1, 8'h00);
        run(0, 0, 8'h80); run(1, 0, 8'h34); run(0, 1, 8'h00);
        run(0, 0, 8'h30); run(1, 0, 8'h35); run(0, 1, 8'h00);
        run(0, 0, 8'h06); run(0, 0, 8'hCF); run(1, 0, 8'h36); run(0, 1, 8'h00);
        run(0, 0, 8'h38);
        cur_req = "R8";
        run(0, 0, 8'h07); run(0, 0, 8'h82); run(1, 0, 8'h61);
        run(0, 0, 8'h05); run(1, 0, 8'h62); run(1, 0, 8'h63);
        run(1, 1, 8'h00); run(1, 1, 8'h00);
        run(0, 0, 8'h06);
        cur_req = "R9";
        run(0, 0, 8'h85); run(0, 0, 8'h14); run(0, 1, 8'h00); run(1, 1, 8'h00);
        run(0, 0, 8'h10); run(0, 0, 8'h10); run(0, 1, 8'h00);
        run(0, 0, 8'h18); run(0, 0, 8'h18); run(0, 0, 8'h1C); run(0, 1, 8'h00);
        run(0, 0, 8'h1C); run(0, 0, 8'h1C);
        cur_req = "R3";
        run(0, 0, 8'h85); run(1, 0, 8'h51); run(0, 0, 8'h02); run(0, 1, 8'h00);
        run(0, 0, 8'h85); run(1, 1, 8'h00);
        cur_req = "R6";
        run(0, 0, 8'h48); run(1, 0, 8'h1F); run(1, 0, 8'h11); run(0, 1, 8'h00);
        run(0, 0, 8'h48); run(1, 1, 8'h00); run(1, 1, 8'h00);
        run(0, 0, 8'h7F); run(1, 0, 8'h0E); run(0, 1, 8'h00);
        cur_req = "R2";
        run(0, 0, 8'h04); run(0, 0, 8'h01); run(1, 0, 8'h5A); run(0, 1, 8'h00);
        run(0, 0, 8'h90); run(1, 1, 8'h00); run(1, 1, 8'h00);
        cur_req = "R5";
        acc(0, 0, 8'h03);
        acc(0, 0, 8'hB3);
        acc(1, 0, 8'h77);
        acc(0, 1, 8'h00);
        cur_req = "R4";
        acc(0, 1, 8'h00);
        idle();
        cur_req = "R5";
        run(0, 1, 8'h00);
        run(0, 0, 8'h80); run(1, 1, 8'h00);
        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule